// File: doc/BRIEF.md
# Exception Entry Sequencer

This block steers a processor core into an exception handler. Up to eight exception sources raise single-cycle request pulses; the block remembers each one until it is serviced and takes one at a time. When a request is taken, it records the context of the interrupted instruction (the aligned program counter, the faulting effective address, and the status word as it stood), builds the status word the handler will run under, and presents the handler's entry address to the fetch unit. It then holds the pipeline stalled for a fixed number of cycles.

The status register itself lives outside the block. The core feeds the current value in on `srIn` and loads `srOut` back into its register in the cycle `excTaken` is high. Recognition is governed by the exception-enable bit of that word. If a fresh request arrives while that bit is clear and no entry is in progress, the block raises a permanent fatal halt instead of entering a handler. The `pcIn`, `faultAddr` and `delaySlot` values captured are the ones present in the cycle the request is taken.

Top module: `exc_entry_ctrl_top`

## Requirements
- R1: When `delaySlot` is 1 in the cycle a request is taken, the saved PC is derived from `pcIn - 4` rather than from `pcIn`.
- R2: A new request (a line going high that was not already pending) while the exception-enable bit (`srIn` bit 2) is 0 and no stall is running sets `halt`. Once set, `halt` stays 1 until reset, no further request is taken, and `epcr`, `eear`, `esr`, `srOut`, `newPc` and `newPcNext` keep their values.
- R3: `epcr` receives the saved PC with bits 1:0 forced to 0.
- R4: `eear` receives the `faultAddr` value present in the cycle the request is taken.
- R5: `esr` receives the whole unmodified `srIn` value from the cycle the request is taken.
- R6: `srOut` is the taken-cycle `srIn` with bit 0 (supervisor) set, bits 2 (exception enable), 5 (data translation) and 6 (instruction translation) cleared, and all other bits unchanged.
- R7: For source i the vector code is (i+1)*0x100. `newPc` equals that code, and `newPcNext` equals `newPc + 4`.
- R8: Source 3 is the system-call source. For it, `newPc` equals its code minus 4 (0x3FC) and `newPcNext` equals the code (0x400).
- R9: `stall` is 1 for exactly 7 consecutive cycles, beginning in the cycle after a request is taken. No request is taken while `stall` is 1.
- R10: `excTaken` is a registered pulse that is 1 for one cycle, in the cycle after the clock edge at which the request is taken. The outputs `epcr`, `eear`, `esr`, `srOut`, `newPc` and `newPcNext` are valid in that cycle.
- R11: A request is taken only when exception enable is 1, `stall` is 0 and `halt` is 0. Among all pending and newly raised lines, the lowest-numbered one is taken first. The others stay pending, without raising `halt`, until enable is 1 again.
- R12: While reset is applied, and after it is released, all outputs are 0 until the first request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excReq | input | 8 | Request pulse per exception source |
| faultAddr | input | 32 | Effective address of the faulting access |
| pcIn | input | 32 | PC of the current instruction |
| delaySlot | input | 1 | Current instruction sits in a branch delay slot |
| srIn | input | 16 | Current status word |
| excTaken | output | 1 | One-cycle pulse: entry performed, outputs valid |
| stall | output | 1 | Pipeline stall during the entry window |
| halt | output | 1 | Sticky fatal halt |
| newPc | output | 32 | Redirect address for fetch |
| newPcNext | output | 32 | Next PC after the redirect |
| srOut | output | 16 | Status word for the handler |
| epcr | output | 32 | Saved PC |
| eear | output | 32 | Saved effective address |
| esr | output | 16 | Saved status word |

## Verification
The hardest case to reach is a request that arrives inside the stall window. By then the handler's status word has already cleared exception enable, yet the request must be held rather than halt the core. The stimulus raises a second source a few cycles into a stall, leaves enable clear for several cycles after the stall ends, and only then restores it. The bench's model must then show the held source taken, with no halt. A second case raises two sources in the same cycle. The higher-numbered source is then made to wait out both the stall and a stretch with enable clear.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 32;
  localparam int SRW  = 16;

  // status word bit positions
  localparam int SR_SUPV = 0;
  localparam int SR_EXEN = 2;
  localparam int SR_DTE  = 5;
  localparam int SR_ITE  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // perform entry this cycle
    logic syscall;   // granted source is the system-call source
  } ctrlStrobeT;
endpackage

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int SYSCALL_IDX  = 3,
  parameter int STALL_CYCLES = 7,
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] excReq,
  input  logic               excEnable,
  output ctrlStrobeT         strobe,
  output logic [IDXW-1:0]    grantIdx,
  output logic               stall,
  output logic               halt
);
  localparam int CNTW = $clog2(STALL_CYCLES + 1);

  logic [NUM_SRC-1:0] pendQ, pendAll, arrival, grantVec;
  logic [CNTW-1:0]    cntQ;
  logic               haltQ, idle, accept, setHalt;

  assign pendAll  = pendQ | excReq;
  assign arrival  = excReq & ~pendQ;
  assign grantVec = pendAll & (~pendAll + NUM_SRC'(1));

  always_comb begin
    grantIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pendAll[i]) grantIdx = IDXW'(i);
  end

  assign idle    = (cntQ == '0);
  assign accept  = idle && !haltQ && excEnable && (|pendAll);
  assign setHalt = idle && !haltQ && !excEnable && (|arrival);

  assign strobe.capture = accept;
  assign strobe.syscall = grantVec[SYSCALL_IDX];
  assign stall = !idle;
  assign halt  = haltQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      cntQ  <= '0;
      haltQ <= 1'b0;
    end else begin
      if (accept) begin
        pendQ <= pendAll & ~grantVec;
        cntQ  <= CNTW'(STALL_CYCLES);
      end else begin
        pendQ <= pendAll;
        if (!idle) cntQ <= cntQ - CNTW'(1);
      end
      if (setHalt) haltQ <= 1'b1;
    end
  end

  // R2
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltQ |=> haltQ);

  // R9
  stall_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> stall);

  // R11
  grant_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));
endmodule

// File: rtl/exc_entry_dp.sv
module exc_entry_dp
  import exc_entry_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int VEC_STRIDE = 'h100,
  parameter int INSN_BYTES = 4,
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobeT      strobe,
  input  logic [IDXW-1:0] grantIdx,
  input  logic [XLEN-1:0] pcIn,
  input  logic [XLEN-1:0] faultAddr,
  input  logic            delaySlot,
  input  logic [SRW-1:0]  srIn,
  output logic            excTaken,
  output logic [XLEN-1:0] newPc,
  output logic [XLEN-1:0] newPcNext,
  output logic [SRW-1:0]  srOut,
  output logic [XLEN-1:0] epcr,
  output logic [XLEN-1:0] eear,
  output logic [SRW-1:0]  esr
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] vecCode, vecPc, faultPc;
  logic [SRW-1:0]  srEntry;

  assign vecCode = XLEN'(VEC_STRIDE) * (XLEN'(grantIdx) + XLEN'(1));
  assign vecPc   = strobe.syscall ? vecCode - STEP : vecCode;
  assign faultPc = delaySlot ? pcIn - STEP : pcIn;

  always_comb begin
    srEntry          = srIn;
    srEntry[SR_DTE]  = 1'b0;
    srEntry[SR_ITE]  = 1'b0;
    srEntry[SR_EXEN] = 1'b0;
    srEntry[SR_SUPV] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excTaken  <= 1'b0;
      newPc     <= '0;
      newPcNext <= '0;
      srOut     <= '0;
      epcr      <= '0;
      eear      <= '0;
      esr       <= '0;
    end else begin
      excTaken <= strobe.capture;
      if (strobe.capture) begin
        newPc     <= vecPc;
        newPcNext <= vecPc + STEP;
        srOut     <= srEntry;
        epcr      <= {faultPc[XLEN-1:2], 2'b00};
        eear      <= faultAddr;
        esr       <= srIn;
      end
    end
  end

  // R10
  taken_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |=> !excTaken);

  // R3
  epcr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> (epcr[1:0] == 2'b00));

  // R7
  pc_link_chk: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> (newPcNext == newPc + STEP));

  // R2
  regs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(epcr) && $stable(eear) && $stable(esr) && $stable(srOut)));
endmodule

// File: rtl/exc_entry_ctrl_top.sv
module exc_entry_ctrl_top
  import exc_entry_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int SYSCALL_IDX  = 3,
  parameter int STALL_CYCLES = 7,
  parameter int VEC_STRIDE   = 'h100,
  parameter int INSN_BYTES   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] excReq,
  input  logic [XLEN-1:0]    faultAddr,
  input  logic [XLEN-1:0]    pcIn,
  input  logic               delaySlot,
  input  logic [SRW-1:0]     srIn,
  output logic               excTaken,
  output logic               stall,
  output logic               halt,
  output logic [XLEN-1:0]    newPc,
  output logic [XLEN-1:0]    newPcNext,
  output logic [SRW-1:0]     srOut,
  output logic [XLEN-1:0]    epcr,
  output logic [XLEN-1:0]    eear,
  output logic [SRW-1:0]     esr
);
  localparam int IDXW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  ctrlStrobeT      strobe;
  logic [IDXW-1:0] grantIdx;

  exc_entry_ctrl #(
    .NUM_SRC(NUM_SRC), .SYSCALL_IDX(SYSCALL_IDX), .STALL_CYCLES(STALL_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excEnable(srIn[SR_EXEN]),
    .strobe(strobe), .grantIdx(grantIdx), .stall(stall), .halt(halt)
  );

  exc_entry_dp #(
    .NUM_SRC(NUM_SRC), .VEC_STRIDE(VEC_STRIDE), .INSN_BYTES(INSN_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grantIdx(grantIdx),
    .pcIn(pcIn), .faultAddr(faultAddr), .delaySlot(delaySlot), .srIn(srIn),
    .excTaken(excTaken), .newPc(newPc), .newPcNext(newPcNext), .srOut(srOut),
    .epcr(epcr), .eear(eear), .esr(esr)
  );
endmodule

// File: tb/exc_entry_ctrl_top_tb.sv
module exc_entry_ctrl_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  excReq = '0;
  logic [31:0] faultAddr = '0, pcIn = '0;
  logic        delaySlot = 1'b0;
  logic [15:0] swSr = '0;
  logic        excTaken, stall, halt;
  logic [31:0] newPc, newPcNext, epcr, eear;
  logic [15:0] srOut, esr;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  exc_entry_ctrl_top u_dut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .faultAddr(faultAddr), .pcIn(pcIn),
    .delaySlot(delaySlot), .srIn(swSr), .excTaken(excTaken), .stall(stall),
    .halt(halt), .newPc(newPc), .newPcNext(newPcNext), .srOut(srOut),
    .epcr(epcr), .eear(eear), .esr(esr)
  );

  // behavioural reference model
  logic [7:0]  mPend, mAll, mArr;
  logic [31:0] mEpcr, mEear, mPc, mPcN;
  logic [15:0] mEsr, mSr;
  logic        mTaken, mHalt;
  int          mCnt, mGrant;

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '0; mEpcr = '0; mEear = '0; mPc = '0; mPcN = '0;
      mEsr = '0; mSr = '0; mTaken = 0; mHalt = 0; mCnt = 0;
    end else begin
      mAll = mPend | excReq;
      mArr = excReq & ~mPend;
      mGrant = -1;
      for (int i = 0; i < 8; i++) if (mAll[i] && mGrant < 0) mGrant = i;
      mTaken = (mCnt == 0) && !mHalt && swSr[2] && (mGrant >= 0);
      if (mTaken) begin
        mEpcr = (delaySlot ? pcIn - 4 : pcIn) & ~32'h3;
        mEear = faultAddr;
        mEsr  = swSr;
        mSr   = (swSr & ~16'h0064) | 16'h0001;
        mPc   = 32'((mGrant + 1) * 256 - ((mGrant == 3) ? 4 : 0));
        mPcN  = mPc + 4;
        mCnt  = 7;
        mPend = mAll & ~(8'd1 << mGrant);
      end else begin
        if (mCnt == 0 && !mHalt && !swSr[2] && mArr != 0) mHalt = 1;
        if (mCnt != 0) mCnt = mCnt - 1;
        mPend = mAll;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      chk("R10 excTaken", 32'(excTaken), 32'(mTaken));
      chk("R9 stall", 32'(stall), 32'(mCnt != 0));
      chk("R2 halt", 32'(halt), 32'(mHalt));
      chk("R1 R3 epcr", epcr, mEpcr);
      chk("R4 eear", eear, mEear);
      chk("R5 esr", 32'(esr), 32'(mEsr));
      chk("R6 srOut", 32'(srOut), 32'(mSr));
      chk("R7 R8 R11 newPc", newPc, mPc);
      chk("R7 newPcNext", newPcNext, mPcN);
      if (excTaken) swSr = srOut;   // core loads handler status word
    end
  end

  task automatic pulse(input logic [7:0] req, input logic [31:0] pc,
                       input logic [31:0] ea, input logic ds);
    @(negedge clk);
    excReq = req; pcIn = pc; faultAddr = ea; delaySlot = ds;
    @(negedge clk);
    excReq = '0; delaySlot = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enable();
    @(negedge clk);
    swSr = swSr | 16'h0064;
  endtask

  initial begin
    swSr = 16'hA064;
    idle(3);
    // R12: reset state
    chk("R12 reset excTaken/stall/halt", {29'd0, excTaken, stall, halt}, 32'd0);
    chk("R12 reset newPc", newPc, 32'd0);
    chk("R12 reset epcr", epcr, 32'd0);
    @(negedge clk); rstN = 1'b1;
    idle(2);
    chk("R12 after reset srOut", 32'(srOut), 32'd0);

    // basic entry, unaligned PC
    pulse(8'h01, 32'h0000_2003, 32'hDEAD_0010, 1'b0);
    chk("R10 taken after request", 32'(excTaken), 32'd1);
    chk("R3 aligned epcr", epcr, 32'h0000_2000);
    idle(9); enable();

    // delay slot fault
    pulse(8'h02, 32'h0000_3000, 32'h0000_5555, 1'b1);
    chk("R1 delay slot epcr", epcr, 32'h0000_2FFC);
    chk("R7 vector source 1", newPc, 32'h0000_0200);
    idle(9); enable();

    // system call
    pulse(8'h08, 32'h0000_4444, 32'h0, 1'b0);
    chk("R8 syscall newPc", newPc, 32'h0000_03FC);
    chk("R8 syscall newPcNext", newPcNext, 32'h0000_0400);
    idle(9); enable();

    // two at once: lowest first, the other held while enable is clear
    pulse(8'h24, 32'h0000_5000, 32'h0000_7000, 1'b0);
    chk("R11 lowest first", newPc, 32'h0000_0300);
    idle(14);
    chk("R11 held, no halt", 32'(halt), 32'd0);
    enable();
    idle(2);
    chk("R11 held source taken", newPc, 32'h0000_0600);
    idle(9); enable();

    // arrival during stall is held
    pulse(8'h01, 32'h0000_6000, 32'h0, 1'b0);
    idle(2);
    pulse(8'h40, 32'h0000_6100, 32'h0000_6666, 1'b0);
    idle(8);
    chk("R11 arrival in stall no halt", 32'(halt), 32'd0);
    enable();
    idle(2);
    chk("R11 stall arrival taken", newPc, 32'h0000_0700);
    idle(9);

    // enable left clear: new request halts
    pulse(8'h10, 32'h0000_9000, 32'h0000_9999, 1'b0);
    chk("R2 halt raised", 32'(halt), 32'd1);
    chk("R2 regs unchanged", newPc, 32'h0000_0700);
    enable();
    pulse(8'h01, 32'h0000_A000, 32'h0, 1'b0);
    idle(3);
    chk("R2 halt sticky", 32'(halt), 32'd1);
    chk("R2 no entry after halt", eear, 32'h0000_6666);
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule